// File: doc/BRIEF.md
# Byte-Lane Memory Port with Lane and Address Parity

This block sits between a requester and a 64-bit wide synchronous memory that is organised as eight one-byte banks, each bank storing a parity bit beside its byte. The requester presents a byte address, a transfer size and a read or write flag. The block works out which byte lanes of the addressed 8-byte row take part. It drives active-low bank enables and active-high per-lane write strobes for those lanes, and it forwards the row address and write data. A single transfer can move a byte, a word, a doubleword or a quadword, provided the bytes stay inside one row.

On writes the block produces an even parity bit for each enabled lane. On reads it checks every enabled lane against the parity bit returned by memory and reports a per-lane error vector. Separately, it checks the upper address bits against a parity bit supplied with the request and raises a one-cycle flag on a mismatch. That flag is report-only: the transfer proceeds exactly as it would with good parity. A request whose bytes would spill past the end of a row is refused with its own error flag, and no lane is touched.

Top module: `blane_mem_port`

## Requirements
- R1: One cycle after a valid request, memBankEnN is low exactly on lanes a to a+n-1 and high on all others. Here a is reqAddr[2:0], and n is 1, 2, 4 or 8 for reqSize 0, 1, 2 or 3. Lane i carries data bits 8i+7 to 8i.
- R2: memWrStrobe is high, in the same cycle as the enables, only on enabled lanes of a write; it stays all zero for reads.
- R3: When a+n exceeds 8, sizeErr is high for one cycle, every enable stays high, no strobe is raised, and no read result is produced.
- R4: On a write, memWrData equals wrData, and memWrPar[i] is the XOR of lane i's byte (even parity) for each enabled lane and 0 for each disabled lane.
- R5: Two cycles after the enables of a read, rdValid is high for one cycle. rdData then holds memory's bytes on the enabled lanes and zero on all other lanes.
- R6: With rdValid, rdParErr[i] is 1 exactly when lane i is enabled and the XOR of its byte and its returned parity bit is 1; disabled lanes never flag.
- R7: One cycle after any valid request, including a refused one, addrParChk is high exactly when reqAddrPar differs from the XOR of reqAddr[31:5].
- R8: An address parity mismatch changes nothing else: enables, strobes, write parity and the stored data are the same as with matching parity.
- R9: While enables are low, memAddr equals reqAddr[31:3] of the request being served.
- R10: During and right after reset, all enables are high, all strobes are zero, and rdValid, sizeErr and addrParChk are low.
- R11: In a cycle that follows no valid request, all enables are high and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 write, 0 read |
| reqAddr | input | 32 | Byte address |
| reqSize | input | 2 | 0 byte, 1 word, 2 doubleword, 3 quadword |
| reqAddrPar | input | 1 | Parity bit supplied for reqAddr[31:5] |
| wrData | input | 64 | Write data, lane i in bits 8i+7:8i |
| memRdData | input | 64 | Row data returned by memory |
| memRdPar | input | 8 | Per-lane parity returned by memory |
| memBankEnN | output | 8 | Active-low bank enables |
| memWrStrobe | output | 8 | Per-lane write strobes |
| memAddr | output | 29 | Row address |
| memWrData | output | 64 | Write data to memory |
| memWrPar | output | 8 | Generated per-lane write parity |
| rdData | output | 64 | Read result, disabled lanes zero |
| rdValid | output | 1 | Read result valid |
| rdParErr | output | 8 | Per-lane read parity error |
| sizeErr | output | 1 | Request refused for crossing a row |
| addrParChk | output | 1 | Address parity mismatch flag |

## Verification
Two of the block's reports can fall in the same cycle: the row-crossing refusal and the address parity flag, since both are judged in the cycle after the request. The bench sends row-crossing requests of every size that carry a deliberately wrong address parity bit, and random traffic mixes both faults. It expects both flags together, all enables high, and no read result. The read parity check is also driven with corruption injected on enabled and disabled lanes in the same transfer, so lane masking is judged per bit.

// File: rtl/blane_pkg.sv
package blane_pkg;
  localparam int unsigned LANES   = 8;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned APAR_LO = 5;
  localparam int unsigned SIZE_W  = 2;
  localparam int unsigned DATA_W  = LANES * LANE_W;
  localparam int unsigned OFS_W   = $clog2(LANES);
  localparam int unsigned ROW_W   = ADDR_W - OFS_W;
  localparam int unsigned HI_W    = ADDR_W - APAR_LO;

  typedef logic [LANES-1:0] laneVec_t;

  // Strobes from the request decoder to the datapath
  typedef struct packed {
    logic     issue;
    logic     write;
    logic     sizeErr;
    logic     addrBad;
    laneVec_t lanes;
  } busStrobe_t;
endpackage

// File: rtl/blane_ctl.sv
module blane_ctl
  import blane_pkg::*;
(
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [OFS_W-1:0]  reqOfs,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [HI_W-1:0]   reqAddrHi,
  input  logic              reqAddrPar,
  output busStrobe_t        ctlOut
);
  localparam int unsigned CNT_W = OFS_W + 2;

  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] endPos;
  logic             crossRow;
  laneVec_t         inSpan;

  always_comb begin
    span     = CNT_W'(1) << reqSize;
    endPos   = CNT_W'(reqOfs) + span;
    crossRow = endPos > CNT_W'(LANES);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign inSpan[g] = (CNT_W'(g) >= CNT_W'(reqOfs)) && (CNT_W'(g) < endPos);
  end

  always_comb begin
    ctlOut.issue   = reqValid & ~crossRow;
    ctlOut.write   = reqWrite;
    ctlOut.sizeErr = reqValid & crossRow;
    ctlOut.addrBad = reqValid & ((^reqAddrHi) != reqAddrPar);
    ctlOut.lanes   = (reqValid & ~crossRow) ? inSpan : '0;
  end
endmodule

// File: rtl/blane_dp.sv
module blane_dp
  import blane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        ctlIn,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memRdData,
  input  laneVec_t          memRdPar,
  output laneVec_t          memBankEnN,
  output laneVec_t          memWrStrobe,
  output logic [ROW_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWrData,
  output laneVec_t          memWrPar,
  output logic [DATA_W-1:0] rdData,
  output laneVec_t          rdParErr,
  output logic              rdValid,
  output logic              sizeErr,
  output logic              addrParChk
);
  laneVec_t          enQ, strbQ, parQ, rdLaneS1, rdLaneS2;
  logic              rdS1, rdS2;
  laneVec_t          wrParNext, rdErrNext;
  logic [DATA_W-1:0] rdMasked;
  logic              doWrite;

  assign doWrite = ctlIn.issue & ctlIn.write;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wrParNext[g] = doWrite & ctlIn.lanes[g] & (^wrData[g*LANE_W +: LANE_W]);
    assign rdMasked[g*LANE_W +: LANE_W] =
      rdLaneS2[g] ? memRdData[g*LANE_W +: LANE_W] : '0;
    assign rdErrNext[g] = rdLaneS2[g] &
      ((^memRdData[g*LANE_W +: LANE_W]) ^ memRdPar[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ        <= '0;
      strbQ      <= '0;
      parQ       <= '0;
      memAddr    <= '0;
      memWrData  <= '0;
      sizeErr    <= 1'b0;
      addrParChk <= 1'b0;
      rdS1       <= 1'b0;
      rdS2       <= 1'b0;
      rdLaneS1   <= '0;
      rdLaneS2   <= '0;
      rdValid    <= 1'b0;
      rdData     <= '0;
      rdParErr   <= '0;
    end else begin
      enQ        <= ctlIn.lanes;
      strbQ      <= doWrite ? ctlIn.lanes : '0;
      parQ       <= wrParNext;
      if (ctlIn.issue) memAddr <= reqRow;
      if (doWrite)     memWrData <= wrData;
      sizeErr    <= ctlIn.sizeErr;
      addrParChk <= ctlIn.addrBad;
      rdS1       <= ctlIn.issue & ~ctlIn.write;
      rdLaneS1   <= (ctlIn.issue & ~ctlIn.write) ? ctlIn.lanes : '0;
      rdS2       <= rdS1;
      rdLaneS2   <= rdLaneS1;
      rdValid    <= rdS2;
      rdData     <= rdMasked;
      rdParErr   <= rdErrNext;
    end
  end

  assign memBankEnN  = ~enQ;
  assign memWrStrobe = strbQ;
  assign memWrPar    = parQ;

  AST_STROBE_IN_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (memWrStrobe & memBankEnN) == '0); // R2
  AST_PAR_IN_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (memWrPar & memBankEnN) == '0); // R4
  AST_REFUSED_NO_LANES: assert property (@(posedge clk) disable iff (!rstN)
    sizeErr |-> (&memBankEnN && memWrStrobe == '0)); // R3
  AST_RD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(!(&memBankEnN) && memWrStrobe == '0, 2)); // R5
  AST_PARERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (rdParErr != '0) |-> rdValid); // R6
  AST_ADDRCHK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    addrParChk |-> $past(ctlIn.issue || ctlIn.sizeErr)); // R7
endmodule

// File: rtl/blane_mem_port.sv
module blane_mem_port
  import blane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqAddrPar,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [LANES-1:0]  memRdPar,
  output logic [LANES-1:0]  memBankEnN,
  output logic [LANES-1:0]  memWrStrobe,
  output logic [ROW_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [LANES-1:0]  memWrPar,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [LANES-1:0]  rdParErr,
  output logic              sizeErr,
  output logic              addrParChk
);
  busStrobe_t ctlBus;

  blane_ctl ctl_i (
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqOfs     (reqAddr[OFS_W-1:0]),
    .reqSize    (reqSize),
    .reqAddrHi  (reqAddr[ADDR_W-1:APAR_LO]),
    .reqAddrPar (reqAddrPar),
    .ctlOut     (ctlBus)
  );

  blane_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctlIn      (ctlBus),
    .reqRow     (reqAddr[ADDR_W-1:OFS_W]),
    .wrData     (wrData),
    .memRdData  (memRdData),
    .memRdPar   (memRdPar),
    .memBankEnN (memBankEnN),
    .memWrStrobe(memWrStrobe),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .memWrPar   (memWrPar),
    .rdData     (rdData),
    .rdParErr   (rdParErr),
    .rdValid    (rdValid),
    .sizeErr    (sizeErr),
    .addrParChk (addrParChk)
  );
endmodule

// File: tb/blane_mem_port_tb_top.sv
`timescale 1ns/1ps
module blane_mem_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqAddrPar = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [63:0] wrData = '0;
  logic [63:0] memRdData;
  logic [7:0]  memRdPar;
  logic [7:0]  memBankEnN, memWrStrobe, memWrPar, rdParErr;
  logic [28:0] memAddr;
  logic [63:0] memWrData, rdData;
  logic        rdValid, sizeErr, addrParChk;
  logic [7:0]  injMask = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  blane_mem_port dut_i (.*);

  // memory model: 16 rows, data plus stored parity
  logic [63:0] mdData [16];
  logic [7:0]  mdPar  [16];
  logic [63:0] shMem  [16];

  always @(posedge clk) begin
    if (memBankEnN != 8'hFF) begin
      if (memWrStrobe != 8'h00) begin
        for (int i = 0; i < 8; i++)
          if (!memBankEnN[i] && memWrStrobe[i]) begin
            mdData[memAddr[3:0]][i*8 +: 8] <= memWrData[i*8 +: 8];
            mdPar[memAddr[3:0]][i] <= memWrPar[i];
          end
      end else begin
        memRdData <= mdData[memAddr[3:0]];
        memRdPar  <= mdPar[memAddr[3:0]] ^ injMask;
      end
    end
  end

  function automatic logic [7:0] laneFn(logic [2:0] a, logic [1:0] sz);
    int n = 1 << sz;
    if (int'(a) + n > 8) return 8'h00;
    return 8'(((1 << n) - 1) << a);
  endfunction

  function automatic logic [7:0] parFn(logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  function automatic logic [63:0] maskFn(logic [7:0] l);
    logic [63:0] m;
    for (int i = 0; i < 8; i++) m[i*8 +: 8] = {8{l[i]}};
    return m;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic wr, input logic [31:0] addr, input logic [1:0] sz,
                       input logic [63:0] data, input logic badAp, input logic [7:0] inj);
    logic [7:0] lanes;
    lanes = laneFn(addr[2:0], sz);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = sz; wrData = data;
    reqAddrPar = (^addr[31:5]) ^ badAp; injMask = inj;
    @(negedge clk);
    reqValid = 1'b0;
    chk(memBankEnN == ~lanes, "R1 enables", 64'(memBankEnN), 64'(~lanes));
    chk(memWrStrobe == (wr ? lanes : 8'h00), "R2 strobes", 64'(memWrStrobe),
        64'(wr ? lanes : 8'h00));
    chk(sizeErr == (lanes == 8'h00), "R3 sizeErr", 64'(sizeErr), 64'(lanes == 8'h00));
    chk(addrParChk == badAp, "R7 addrParChk", 64'(addrParChk), 64'(badAp));
    if (lanes != 8'h00)
      chk(memAddr == addr[31:3], "R9 memAddr", 64'(memAddr), 64'(addr[31:3]));
    if (wr && lanes != 8'h00) begin
      chk(memWrPar == (parFn(data) & lanes), "R4 R8 write parity", 64'(memWrPar),
          64'(parFn(data) & lanes));
      chk(memWrData == data, "R4 write data", memWrData, data);
      for (int i = 0; i < 8; i++)
        if (lanes[i]) shMem[addr[6:3]][i*8 +: 8] = data[i*8 +: 8];
    end
    @(negedge clk);
    chk(memBankEnN == 8'hFF && memWrStrobe == 8'h00, "R11 idle",
        64'({memBankEnN, memWrStrobe}), 64'h0000_FF00);
    @(negedge clk);
    if (!wr && lanes != 8'h00) begin
      chk(rdValid == 1'b1, "R5 rdValid", 64'(rdValid), 64'd1);
      chk(rdData == (shMem[addr[6:3]] & maskFn(lanes)), "R5 R8 rdData", rdData,
          shMem[addr[6:3]] & maskFn(lanes));
      chk(rdParErr == (inj & lanes), "R6 rdParErr", 64'(rdParErr), 64'(inj & lanes));
    end else begin
      chk(rdValid == 1'b0, "R3 R5 no read result", 64'(rdValid), 64'd0);
    end
    injMask = '0;
  endtask

  initial begin
    int unsigned seed;
    for (int r = 0; r < 16; r++) begin
      mdData[r] = '0; mdPar[r] = '0; shMem[r] = '0;
    end
    memRdData = '0; memRdPar = '0;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(memBankEnN == 8'hFF && memWrStrobe == 8'h00 && !rdValid && !sizeErr && !addrParChk,
        "R10 reset", 64'({memBankEnN, memWrStrobe, rdValid, sizeErr, addrParChk}),
        64'({8'hFF, 8'h00, 3'b000}));
    rstN = 1'b1;
    @(negedge clk);
    chk(memBankEnN == 8'hFF && !rdValid, "R10 after reset", 64'(memBankEnN), 64'hFF);
    // directed corners
    doReq(1, 32'h0000_0007, 2'd0, 64'hA5_00_00_00_00_00_00_00, 0, 8'h00); // lane 7 byte
    doReq(1, 32'h0000_0006, 2'd1, 64'h1234_0000_0000_0000, 0, 8'h00);     // word at lane 6
    doReq(0, 32'h0000_0007, 2'd1, 64'h0, 0, 8'h00);                       // R3 word cross
    doReq(1, 32'h0000_0004, 2'd2, 64'hDEADBEEF_00000000, 0, 8'h00);       // dword upper
    doReq(0, 32'h0000_0005, 2'd2, 64'h0, 1, 8'h00);                       // R3 with R7
    doReq(1, 32'hF000_0008, 2'd3, 64'h0123_4567_89AB_CDEF, 1, 8'h00);     // R8 qword, bad AP
    doReq(0, 32'h0000_0009, 2'd3, 64'h0, 1, 8'h00);                       // R3 qword cross, R7
    doReq(0, 32'h0000_0008, 2'd3, 64'h0, 0, 8'h00);                       // R8 readback
    doReq(0, 32'h0000_0004, 2'd2, 64'h0, 0, 8'h81);                       // R6 lane 7 only flags
    doReq(0, 32'h0000_0006, 2'd1, 64'h0, 1, 8'h40);                       // R6 with R7
    // random traffic
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      a = $urandom();
      doReq(1'($urandom() & 1), a, 2'($urandom()), {$urandom(), $urandom()},
            1'(($urandom() & 7) == 0), (($urandom() & 3) == 0) ? 8'($urandom()) : 8'h00);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule